// File: doc/BRIEF.md
# SPI Master with Word FIFOs

This block is a register-mapped SPI master for a system bus. Software writes a
configuration word that sets the word length (1 to 32 bits), clock polarity
and phase, which chip select to drive, whether that select is driven by
hardware or held by software, the transmit and receive enables, and an SCLK
divider. It then loads up to four 32-bit words into the transmit FIFO, writes
the number of words minus one into the transfer register, and sets the go bit
in that same write.

The shift engine sends each word MSB first, starting at bit (length-1). It
collects the bits received on MISO into the receive FIFO. When the block
finishes, it raises a ready flag. A level interrupt follows that flag for each
direction whose completion interrupt is enabled. The status word also reports
sticky transmit-overflow and receive-underflow errors, the FIFO empty/full
flags, and a running count of finished words. Ready and both errors are
cleared by writing 1 to them. Two write-only status bits flush the FIFOs.

Top module: `spiw_master`

## Requirements
- R1: After reset, status reads 0x0000_0050 (TX empty bit 4, RX empty bit 6), all `cs_n` lines are high, `sclk` is 0 and `irq` is 0.
- R2: The configuration bits [4:0] hold the word length minus one. Every word takes exactly length SCLK periods. It is sent MSB first from bit (length-1) of the FIFO entry. The received word is right-aligned with zeros above it.
- R3: A write to TXDATA (0x0C) while the TX FIFO (depth 4) is full sets sticky overflow (status bit 2) and drops the word. Status bit 5 shows TX full.
- R4: A read of RXDATA (0x10) while the RX FIFO is empty returns 0 and sets sticky underflow (status bit 3).
- R5: Writing 1 to status bit 1 (ready), bit 2 or bit 3 clears that flag. Writing 0 to it leaves it unchanged.
- R6: The transfer register (0x08) holds the word count minus one in bits [15:0]. A transfer starts only if bit 31 (go) is 1 in that write. Status bits [31:16] count the words finished in the current transfer.
- R7: With transmit disabled (configuration bit 7 = 0), MOSI stays low and the TX FIFO is not read. With receive disabled (bit 8 = 0), nothing is written to the RX FIFO.
- R8: Busy (status bit 0) reads 1 from the cycle after the go write until the final half-period ends. Ready becomes 1 in the cycle busy falls, and the go bit then reads back 0.
- R9: `irq` is 1 while ready is set and either the TX-complete enable (transfer bit 16) is set with transmit enabled, or the RX-complete enable (bit 17) is set with receive enabled.
- R10: Chip-select enables are configuration bits [19:16]. In hardware mode (bit 13 = 0) the selected `cs_n` is low only while busy. In software mode (bit 13 = 1) the selected `cs_n` is low exactly when bit 14 is 1.
- R11: Configuration bit 6 sets the idle level of SCLK. Bit 5 = 0 samples on the leading SCLK edge and bit 5 = 1 samples on the trailing edge. Data launched on MOSI is stable at the edge where it is sampled.
- R12: Writing 1 to status bit 8 empties the TX FIFO, and writing 1 to status bit 9 empties the RX FIFO.
- R13: Within a word, consecutive SCLK edges are div+1 system clocks apart, where div is configuration bits [31:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; pops RXDATA when addressed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The hardest case to reach is a phase-1 transfer of odd word lengths. In that
case the first change edge must not shift, and the final edge both samples
and ends the word. The stimulus draws word length, phase, polarity, divider,
word count and target select at random from a fixed seed, with MISO looped
back to MOSI. A bench monitor captures MOSI at the sampling edges the
requirements name, and it times every edge within a word. Directed runs add a
five-word overrun, a transmit-disabled receive and a go-less arm.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

  // register byte addresses
  localparam logic [4:0] A_CFG  = 5'h00;
  localparam logic [4:0] A_STAT = 5'h04;
  localparam logic [4:0] A_XFER = 5'h08;
  localparam logic [4:0] A_TXD  = 5'h0C;
  localparam logic [4:0] A_RXD  = 5'h10;

  // configuration bit positions
  localparam int CB_CPHA  = 5;
  localparam int CB_CPOL  = 6;
  localparam int CB_TXEN  = 7;
  localparam int CB_RXEN  = 8;
  localparam int CB_CSSW  = 13;
  localparam int CB_CSVAL = 14;
  localparam int CB_CSEN  = 16;
  localparam int CB_DIV   = 24;

  // status bit positions
  localparam int SB_BUSY    = 0;
  localparam int SB_READY   = 1;
  localparam int SB_TXOVF   = 2;
  localparam int SB_RXUNF   = 3;
  localparam int SB_TXEMP   = 4;
  localparam int SB_TXFUL   = 5;
  localparam int SB_RXEMP   = 6;
  localparam int SB_RXFUL   = 7;
  localparam int SB_TXFLUSH = 8;
  localparam int SB_RXFLUSH = 9;
  localparam int SB_CNT     = 16;

  // transfer register bit positions
  localparam int XB_IETX = 16;
  localparam int XB_IERX = 17;
  localparam int XB_GO   = 31;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_TRAIL} seq_t;

  // active-low level of one chip-select line
  function automatic logic cs_level(input logic en, input logic sw,
                                    input logic val, input logic act);
    return !(en && (sw ? val : act));
  endfunction

  // sampling edge test: phase 0 samples even edges, phase 1 odd edges
  function automatic logic is_sample_edge(input logic idx_lsb, input logic cpha);
    return idx_lsb == cpha;
  endfunction

endpackage

// File: rtl/spiw_fifo.sv
module spiw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] P_ONE = 1;

  logic [AW:0]  wp, rp;
  logic [W-1:0] mem [DEPTH];

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign rdata = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + P_ONE;
      if (pop && !empty) rp <= rp + P_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) mem[wp[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/spiw_halfdiv.sv
module spiw_halfdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] D_ONE = 1;
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + D_ONE;
  end
endmodule

// File: rtl/spiw_engine.sv
module spiw_engine import spiw_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              cpha,
  input  logic              cpol,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [CNT_W-1:0]  blk_m1,
  input  logic [DIV_W-1:0]  div,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_empty,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              busy,
  output logic              done,
  output logic              edge_evt,
  output logic [CNT_W-1:0]  words_done,
  output logic              sclk,
  output logic              mosi
);
  localparam int EW = LEN_W + 1;
  localparam logic [EW-1:0]    E_ONE = 1;
  localparam logic [CNT_W-1:0] C_ONE = 1;

  seq_t              state;
  logic [DATA_W-1:0] sh_tx, sh_rx, rx_nxt;
  logic [EW-1:0]     edge_idx;
  logic [CNT_W-1:0]  wcnt;
  logic              sclk_q, tick, run;
  logic              last_edge, samp_edge, shift_edge;

  assign run = (state == S_SHIFT) || (state == S_TRAIL);

  spiw_halfdiv #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .div  (div),
    .tick (tick)
  );

  assign edge_evt   = (state == S_SHIFT) && tick;
  assign last_edge  = (edge_idx == {len_m1, 1'b1});
  assign samp_edge  = is_sample_edge(edge_idx[0], cpha);
  assign shift_edge = !samp_edge && (edge_idx != '0);
  assign rx_nxt     = samp_edge ? {sh_rx[DATA_W-2:0], miso} : sh_rx;

  assign tx_pop     = (state == S_LOAD) && tx_en && !tx_empty;
  assign rx_push    = edge_evt && last_edge && rx_en;
  assign rx_word    = rx_nxt;
  assign done       = (state == S_TRAIL) && tick;
  assign busy       = (state != S_IDLE);
  assign words_done = wcnt;
  assign sclk       = busy ? sclk_q : cpol;
  assign mosi       = tx_en && sh_tx[len_m1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sh_tx    <= '0;
      sh_rx    <= '0;
      edge_idx <= '0;
      wcnt     <= '0;
      sclk_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state  <= S_LOAD;
            wcnt   <= '0;
            sclk_q <= cpol;
          end
        end
        S_LOAD: begin
          sh_tx    <= (tx_en && !tx_empty) ? tx_word : '0;
          sh_rx    <= '0;
          edge_idx <= '0;
          state    <= S_SHIFT;
        end
        S_SHIFT: begin
          if (tick) begin
            sclk_q   <= ~sclk_q;
            sh_rx    <= rx_nxt;
            edge_idx <= edge_idx + E_ONE;
            if (shift_edge) sh_tx <= sh_tx << 1;
            if (last_edge) begin
              wcnt  <= wcnt + C_ONE;
              state <= (wcnt == blk_m1) ? S_TRAIL : S_LOAD;
            end
          end
        end
        S_TRAIL: begin
          if (tick) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spiw_master.sv
module spiw_master import spiw_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int NCS    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [NCS-1:0] cs_n
);
  localparam int LEN_W = $clog2(DATA_W);

  // configuration
  logic [LEN_W-1:0] c_len;
  logic             c_cpha, c_cpol, c_txen, c_rxen, c_cssw, c_csval;
  logic [NCS-1:0]   c_csen;
  logic [DIV_W-1:0] c_div;
  // transfer
  logic [CNT_W-1:0] x_blk;
  logic             x_ietx, x_ierx, x_go;
  // status
  logic             st_ready, st_ovf, st_unf;

  logic wr_cfg, wr_stat, wr_xfer, txd_wr, rd_rxd, start;
  logic tx_pop, tx_empty, tx_full, tx_flush;
  logic rx_push, rx_empty, rx_full, rx_flush, rx_pop;
  logic eng_busy, done, edge_evt;
  logic [DATA_W-1:0] tx_head, rx_word, rx_head;
  logic [CNT_W-1:0]  words_done;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_cfg   = bus_wr && (bus_addr == A_CFG);
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);
  assign wr_xfer  = bus_wr && (bus_addr == A_XFER) && !eng_busy;
  assign txd_wr   = bus_wr && (bus_addr == A_TXD);
  assign rd_rxd   = bus_rd && (bus_addr == A_RXD);
  assign start    = wr_xfer && bus_wdata[XB_GO];
  assign tx_flush = wr_stat && bus_wdata[SB_TXFLUSH];
  assign rx_flush = wr_stat && bus_wdata[SB_RXFLUSH];
  assign rx_pop   = rd_rxd && !rx_empty;

  spiw_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(txd_wr), .wdata(bus_wdata[DATA_W-1:0]),
    .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spiw_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
  );

  spiw_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start),
    .len_m1(c_len), .cpha(c_cpha), .cpol(c_cpol),
    .tx_en(c_txen), .rx_en(c_rxen), .blk_m1(x_blk), .div(c_div),
    .tx_word(tx_head), .tx_empty(tx_empty), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .busy(eng_busy), .done(done), .edge_evt(edge_evt),
    .words_done(words_done), .sclk(sclk), .mosi(mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_len <= '0; c_cpha <= 1'b0; c_cpol <= 1'b0;
      c_txen <= 1'b0; c_rxen <= 1'b0; c_cssw <= 1'b0; c_csval <= 1'b0;
      c_csen <= '0; c_div <= '0;
    end else if (wr_cfg) begin
      c_len   <= bus_wdata[LEN_W-1:0];
      c_cpha  <= bus_wdata[CB_CPHA];
      c_cpol  <= bus_wdata[CB_CPOL];
      c_txen  <= bus_wdata[CB_TXEN];
      c_rxen  <= bus_wdata[CB_RXEN];
      c_cssw  <= bus_wdata[CB_CSSW];
      c_csval <= bus_wdata[CB_CSVAL];
      c_csen  <= bus_wdata[CB_CSEN +: NCS];
      c_div   <= bus_wdata[CB_DIV +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_blk <= '0; x_ietx <= 1'b0; x_ierx <= 1'b0; x_go <= 1'b0;
    end else begin
      if (wr_xfer) begin
        x_blk  <= bus_wdata[CNT_W-1:0];
        x_ietx <= bus_wdata[XB_IETX];
        x_ierx <= bus_wdata[XB_IERX];
        x_go   <= bus_wdata[XB_GO];
      end else if (done) begin
        x_go <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ready <= 1'b0; st_ovf <= 1'b0; st_unf <= 1'b0;
    end else begin
      if (done)                                  st_ready <= 1'b1;
      else if (start)                            st_ready <= 1'b0;
      else if (wr_stat && bus_wdata[SB_READY])   st_ready <= 1'b0;

      if (txd_wr && tx_full)                     st_ovf <= 1'b1;
      else if (wr_stat && bus_wdata[SB_TXOVF])   st_ovf <= 1'b0;

      if (rd_rxd && rx_empty)                    st_unf <= 1'b1;
      else if (wr_stat && bus_wdata[SB_RXUNF])   st_unf <= 1'b0;
    end
  end

  assign irq = st_ready && ((x_ietx && c_txen) || (x_ierx && c_rxen));

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = cs_level(c_csen[i], c_cssw, c_csval, eng_busy);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: begin
        bus_rdata[LEN_W-1:0]      = c_len;
        bus_rdata[CB_CPHA]        = c_cpha;
        bus_rdata[CB_CPOL]        = c_cpol;
        bus_rdata[CB_TXEN]        = c_txen;
        bus_rdata[CB_RXEN]        = c_rxen;
        bus_rdata[CB_CSSW]        = c_cssw;
        bus_rdata[CB_CSVAL]       = c_csval;
        bus_rdata[CB_CSEN +: NCS] = c_csen;
        bus_rdata[CB_DIV +: DIV_W] = c_div;
      end
      A_STAT: begin
        bus_rdata[SB_BUSY]  = eng_busy;
        bus_rdata[SB_READY] = st_ready;
        bus_rdata[SB_TXOVF] = st_ovf;
        bus_rdata[SB_RXUNF] = st_unf;
        bus_rdata[SB_TXEMP] = tx_empty;
        bus_rdata[SB_TXFUL] = tx_full;
        bus_rdata[SB_RXEMP] = rx_empty;
        bus_rdata[SB_RXFUL] = rx_full;
        bus_rdata[SB_CNT +: CNT_W] = words_done;
      end
      A_XFER: begin
        bus_rdata[CNT_W-1:0] = x_blk;
        bus_rdata[XB_IETX]   = x_ietx;
        bus_rdata[XB_IERX]   = x_ierx;
        bus_rdata[XB_GO]     = x_go;
      end
      A_RXD:   bus_rdata[DATA_W-1:0] = rx_empty ? '0 : rx_head;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spiw_checks.sv
module spiw_checks #(
  parameter int NCS   = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             ready,
  input logic             done,
  input logic             sclk,
  input logic             cpol,
  input logic [NCS-1:0]   cs_n,
  input logic             cs_sw,
  input logic             tx_en,
  input logic             tx_pop,
  input logic             rx_en,
  input logic             rx_push,
  input logic             tx_ovf,
  input logic             txd_wr,
  input logic             tx_full,
  input logic [CNT_W-1:0] words_done,
  input logic [CNT_W-1:0] blk_m1
);
  localparam logic [CNT_W-1:0] C_ONE = 1;

  AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> ready);              // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !ready);                 // R8
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (sclk == cpol));             // R11
  AST_CS_HW_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!cs_sw && !busy) |-> (&cs_n));       // R10
  AST_NO_TX_POP: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |-> !tx_pop);                   // R7
  AST_NO_RX_PUSH: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |-> !rx_push);                 // R7
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_ovf) |-> $past(txd_wr && tx_full)); // R3
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n) done |-> (words_done == blk_m1 + C_ONE)); // R6
endmodule

bind spiw_master spiw_checks #(.NCS(NCS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (eng_busy),
  .ready     (st_ready),
  .done      (done),
  .sclk      (sclk),
  .cpol      (c_cpol),
  .cs_n      (cs_n),
  .cs_sw     (c_cssw),
  .tx_en     (c_txen),
  .tx_pop    (tx_pop),
  .rx_en     (c_rxen),
  .rx_push   (rx_push),
  .tx_ovf    (st_ovf),
  .txd_wr    (txd_wr),
  .tx_full   (tx_full),
  .words_done(words_done),
  .blk_m1    (x_blk)
);

// File: tb/sim_spiw_master.sv
module sim_spiw_master;
  localparam logic [4:0] CFG = 5'h00, STAT = 5'h04, XFER = 5'h08, TXD = 5'h0C, RXD = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sclk, mosi, miso;
  logic [3:0]  cs_n;

  always #4 clk = ~clk;
  assign miso = mosi;

  spiw_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  function automatic logic [31:0] mk_cfg(input int len, input int cp, input int cl, input int te,
                                         input int re, input int sw, input int sv, input int cs,
                                         input int dv);
    logic [31:0] c = '0;
    c[4:0] = 5'(len - 1);
    c[5] = cp[0]; c[6] = cl[0]; c[7] = te[0]; c[8] = re[0];
    c[13] = sw[0]; c[14] = sv[0];
    c[16 + cs] = 1'b1;
    c[31:24] = 8'(dv);
    return c;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // SCLK monitor: captures MOSI at the sampling edges, times edges within a word
  bit          mon_on = 0;
  int          cur_len = 8, cur_cpha = 0, cur_div = 0;
  logic [3:0]  exp_cs = 4'hF;
  logic [31:0] mon_words [8];
  int          mon_nw = 0, e_idx = 0, gap = 0, gap_err = 0, cs_err = 0;
  logic [31:0] mon_cap = '0;
  logic        prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (mon_on && (sclk !== prev_sclk)) begin
      if (e_idx > 0 && gap != cur_div) gap_err++;
      if (cs_n !== exp_cs) cs_err++;
      if ((e_idx % 2) == cur_cpha) mon_cap = {mon_cap[30:0], mosi};
      e_idx++;
      gap = 0;
      if (e_idx == 2 * cur_len) begin
        if (mon_nw < 8) mon_words[mon_nw] = mon_cap;
        mon_nw++;
        e_idx = 0;
        mon_cap = '0;
      end
    end else begin
      gap++;
    end
    prev_sclk = sclk;
  end

  task automatic mon_arm(input int len, input int cp, input int dv, input int cs);
    cur_len = len; cur_cpha = cp; cur_div = dv; exp_cs = ~(4'b0001 << cs);
    mon_nw = 0; e_idx = 0; gap = 0; gap_err = 0; cs_err = 0; mon_cap = '0;
    mon_on = 1;
  endtask

  task automatic wait_idle(output logic [31:0] v);
    v = 32'h1;
    for (int i = 0; i < 4000 && v[0]; i++) rd(STAT, v);
    chk("R8 transfer ends", {31'd0, v[0]}, 32'd0);
  endtask

  logic [31:0] tx_data [4];

  task automatic run_xfer(input int len, input int cp, input int cl, input int dv, input int nw,
                          input int te, input int re, input int cs, input int it, input int ir);
    logic [31:0] v, w;
    wr(CFG, mk_cfg(len, cp, cl, te, re, 0, 0, cs, dv));
    if (te != 0) begin
      for (int i = 0; i < nw; i++) begin
        tx_data[i] = $urandom;
        wr(TXD, tx_data[i]);
      end
    end else begin
      wr(TXD, 32'hA5A5_5A5A);
    end
    mon_arm(len, cp, dv, cs);
    wr(XFER, (32'd1 << 31) | (32'(ir) << 17) | (32'(it) << 16) | 32'(nw - 1));
    peek(STAT, v);
    chk("R8 busy set ready clear after go", {30'd0, v[1:0]}, 32'd1);
    wait_idle(v);
    mon_on = 0;
    chk("R8 ready at end", {31'd0, v[1]}, 32'd1);
    chk("R6 running word count", {16'd0, v[31:16]}, 32'(nw));
    peek(XFER, w);
    chk("R8 go self-clears", {31'd0, w[31]}, 32'd0);
    chk("R9 irq level", {31'd0, irq}, 32'(((it != 0) && (te != 0)) || ((ir != 0) && (re != 0))));
    chk("R2 word count on wire", 32'(mon_nw), 32'(nw));
    for (int i = 0; i < nw && i < 8; i++)
      chk("R2 R11 MOSI word", mon_words[i], (te != 0) ? (tx_data[i] & mask_of(len)) : 32'd0);
    if (re != 0) begin
      for (int i = 0; i < nw; i++) begin
        rd(RXD, w);
        chk("R2 received word", w, (te != 0) ? (tx_data[i] & mask_of(len)) : 32'd0);
      end
    end else begin
      peek(STAT, v);
      chk("R7 rx fifo untouched", {31'd0, v[6]}, 32'd1);
    end
    if (te == 0) begin
      peek(STAT, v);
      chk("R7 tx fifo not consumed", {31'd0, v[4]}, 32'd0);
      wr(STAT, 32'd1 << 8);
      peek(STAT, v);
      chk("R12 tx flush", {31'd0, v[4]}, 32'd1);
    end
    chk("R13 half-period errors", 32'(gap_err), 32'd0);
    chk("R10 hw chip select during edges", 32'(cs_err), 32'd0);
    chk("R11 idle sclk level", {31'd0, sclk}, 32'(cl));
    wr(STAT, 32'd1 << 1);
    peek(STAT, v);
    chk("R5 ready cleared by W1C", {31'd0, v[1]}, 32'd0);
    chk("R9 irq drops with ready", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 cs_n at reset", {28'd0, cs_n}, 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    peek(STAT, v);
    chk("R1 status at reset", v, 32'h0000_0050);
    chk("R1 cs_n idle", {28'd0, cs_n}, 32'hF);
    chk("R1 sclk idle", {31'd0, sclk}, 32'd0);
    chk("R1 irq idle", {31'd0, irq}, 32'd0);

    // directed: byte words, phase 0, polarity 0, full duplex
    tx_data[0] = 0;
    run_xfer(8, 0, 0, 1, 2, 1, 1, 0, 1, 0);
    // odd lengths in phase 1, both polarities
    run_xfer(5, 1, 1, 0, 3, 1, 1, 3, 0, 1);
    run_xfer(1, 1, 0, 2, 4, 1, 1, 1, 1, 1);
    run_xfer(32, 0, 1, 0, 1, 1, 1, 2, 1, 0);

    // constrained random transfers
    for (int k = 0; k < 10; k++) begin
      run_xfer($urandom_range(32, 1), $urandom_range(1, 0), $urandom_range(1, 0),
               $urandom_range(3, 0), $urandom_range(4, 1), 1, 1,
               $urandom_range(3, 0), $urandom_range(1, 0), $urandom_range(1, 0));
    end

    // receive only: tx disabled, rx-complete interrupt
    run_xfer(12, 0, 0, 1, 2, 0, 1, 1, 0, 1);
    // transmit only with only the rx interrupt enabled: no irq
    run_xfer(16, 1, 0, 0, 2, 1, 0, 2, 0, 1);

    // R3 overflow and dropped fifth word
    wr(CFG, mk_cfg(8, 0, 0, 1, 0, 0, 0, 0, 0));
    for (int i = 0; i < 5; i++) begin
      if (i < 4) tx_data[i] = 32'h10 + 32'(i);
      wr(TXD, 32'h10 + 32'(i));
    end
    peek(STAT, v);
    chk("R3 tx full flag", {31'd0, v[5]}, 32'd1);
    chk("R3 overflow flag", {31'd0, v[2]}, 32'd1);
    mon_arm(8, 0, 0, 0);
    wr(XFER, (32'd1 << 31) | 32'd3);
    wait_idle(v);
    mon_on = 0;
    chk("R3 four words sent", 32'(mon_nw), 32'd4);
    for (int i = 0; i < 4; i++) chk("R3 kept word", mon_words[i], tx_data[i]);
    chk("R3 fifth word dropped", {31'd0, v[4]}, 32'd1);
    wr(STAT, 32'd0);
    peek(STAT, v);
    chk("R5 zero write keeps overflow", {31'd0, v[2]}, 32'd1);
    wr(STAT, 32'd1 << 2);
    peek(STAT, v);
    chk("R5 overflow W1C", {31'd0, v[2]}, 32'd0);

    // R4 underflow
    rd(RXD, v);
    chk("R4 empty read data", v, 32'd0);
    peek(STAT, v);
    chk("R4 underflow flag", {31'd0, v[3]}, 32'd1);
    wr(STAT, 32'd1 << 1);
    peek(STAT, v);
    chk("R5 other W1C keeps underflow", {31'd0, v[3]}, 32'd1);
    wr(STAT, 32'd1 << 3);
    peek(STAT, v);
    chk("R5 underflow W1C", {31'd0, v[3]}, 32'd0);

    // R6 arm without go
    wr(CFG, mk_cfg(8, 0, 0, 1, 1, 0, 0, 0, 0));
    wr(TXD, 32'h5A);
    wr(XFER, 32'd0);
    repeat (20) @(negedge clk);
    peek(STAT, v);
    chk("R6 no start without go", {31'd0, v[0]}, 32'd0);
    chk("R6 tx word still queued", {31'd0, v[4]}, 32'd0);
    chk("R6 rx still empty", {31'd0, v[6]}, 32'd1);
    wr(STAT, 32'd1 << 8);

    // R12 rx flush
    run_xfer(8, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    wr(CFG, mk_cfg(8, 0, 0, 1, 1, 0, 0, 0, 0));
    wr(TXD, 32'h3C);
    wr(XFER, (32'd1 << 31));
    wait_idle(v);
    chk("R12 rx holds word", {31'd0, v[6]}, 32'd0);
    wr(STAT, 32'd1 << 9);
    peek(STAT, v);
    chk("R12 rx flush empties", {31'd0, v[6]}, 32'd1);

    // R10 software chip select
    wr(CFG, mk_cfg(8, 0, 0, 1, 1, 1, 1, 2, 0));
    @(negedge clk);
    chk("R10 sw select asserted", {28'd0, cs_n}, 32'hB);
    wr(CFG, mk_cfg(8, 0, 0, 1, 1, 1, 0, 2, 0));
    @(negedge clk);
    chk("R10 sw select released", {28'd0, cs_n}, 32'hF);
    wr(CFG, mk_cfg(8, 0, 1, 1, 1, 0, 0, 2, 0));
    @(negedge clk);
    chk("R11 idle level follows polarity", {31'd0, sclk}, 32'd1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule